// File: doc/BRIEF.md
# Dual-Clock FIFO with Ready Flags

This block carries 18-bit words from one clock domain to another through a 512-entry array. The two clocks run free and have no fixed relation to each other. Each side has a small synchronous control set: an active-low select, a direction bit and an enable. The writer may push a word only while its input-ready flag is high. The reader sees words in first-word fall-through style: when output-ready is high, the next word is already sitting in the output register, and a read moves on to the word after it.

Both pointers cross between the domains as Gray codes through a synchronizer of `SYNC_STAGES` flops (two by default). The flags are therefore late but never optimistic. The read side does not drive a pad. It exports `rd_oe`, which a pad ring uses to drive `rd_data` outward.

The write side is a state machine with four states:
- `WS_RESET` moves to `WS_ARM` on the first edge after reset.
- `WS_ARM` moves to `WS_OPEN` on the next edge.
- `WS_OPEN` moves to `WS_FULL` when the accepted word fills the array.
- `WS_FULL` returns to `WS_OPEN` once a freed slot is seen.

The read side has two states:
- `RS_EMPTY` moves to `RS_VALID` when a word is available and is loaded into the output register.
- `RS_VALID` stays where it is on a read that is refilled.
- `RS_VALID` falls back to `RS_EMPTY` on a read that takes the last word.

Top module: `dual_clock_ready_fifo`

## Requirements
- R1: A word on `wr_data` is stored on a rising `wr_clk` edge only when `wr_cs_n`=0, `wr_dir`=1, `wr_en`=1 and `wr_ready`=1. Any other combination stores nothing.
- R2: The output word advances on a rising `rd_clk` edge only when `rd_cs_n`=0, `rd_dir`=0, `rd_en`=1 and `rd_ready`=1. Otherwise `rd_data` and `rd_ready` are unchanged by the attempt.
- R3: `rd_oe` is 1 exactly when `rd_cs_n`=0 and `rd_dir`=0, combinationally.
- R4: While reset is held, `wr_ready`, `rd_ready` and `wr_half_full` are 0. After reset is released, `wr_ready` first reads 1 after the second rising `wr_clk` edge.
- R5: When a word is written into an empty FIFO, `rd_ready` rises on the third rising `rd_clk` edge after the write edge. On that same edge, `rd_data` already shows the word.
- R6: Words leave in exactly the order they were accepted, for any relation between the two clocks.
- R7: The FIFO holds 2^ADDR_W (512) words in the array plus the one in the output register. `wr_ready` drops right after the edge that accepts the word filling the array. It stays 0 while no slot is freed, and it returns to 1 after reads free space.
- R8: `rd_ready` falls only on an edge that reads the last available word. While `rd_ready` is 0, `rd_data` keeps that last word.
- R9: `wr_half_full` is updated on each `wr_clk` edge from the array occupancy as seen by the write side. The output register is not counted. The flag is 1 at 256 or more words and 0 at 255 or fewer, so the write that makes 256 words sets it on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side free-running clock |
| wr_rst_n | input | 1 | Write-side asynchronous reset, active low |
| wr_cs_n | input | 1 | Write-side select, active low |
| wr_dir | input | 1 | Write-side direction, 1 selects writing |
| wr_en | input | 1 | Write enable |
| wr_data | input | DATA_W (18) | Word to store |
| wr_ready | output | 1 | Input-ready flag: room for a word |
| wr_half_full | output | 1 | Array holds at least half its depth |
| rd_clk | input | 1 | Read-side free-running clock |
| rd_rst_n | input | 1 | Read-side asynchronous reset, active low |
| rd_cs_n | input | 1 | Read-side select, active low |
| rd_dir | input | 1 | Read-side direction, 0 selects reading |
| rd_en | input | 1 | Read enable |
| rd_data | output | DATA_W (18) | Output register contents |
| rd_ready | output | 1 | Output-ready flag: `rd_data` holds a fresh word |
| rd_oe | output | 1 | Drive enable for the read-side data pins |

## Verification
The bench measures first-word latency in read-clock edges counted from the write edge. A design that skips a synchronizer stage raises `rd_ready` one edge early, and one that registers the data after the flag shows a stale word. The bench fills the FIFO with the reader stopped. It then checks the exact word count at which `wr_ready` falls and the 255/256 boundary of the half-full flag, so an off-by-one full compare either loses a word or admits a 514th. It drains to empty and hammers reads while not ready and reads with the wrong direction bit. A design that drops the flag too early, or advances on a blocked read, corrupts or repeats words. Unrelated clock periods with random gaps and long full stalls catch any pointer-crossing fault as a reordering against the queue model.

// File: rtl/rfifo_pkg.sv
`timescale 1ns/1ps
package rfifo_pkg;

    // Write-side flow control states.
    typedef enum logic [1:0] {
        WS_RESET = 2'd0,
        WS_ARM   = 2'd1,
        WS_OPEN  = 2'd2,
        WS_FULL  = 2'd3
    } wr_state_e;

    // Read-side output register states.
    typedef enum logic {
        RS_EMPTY = 1'b0,
        RS_VALID = 1'b1
    } rd_state_e;

endpackage

// File: rtl/rfifo_ptr_sync.sv
`timescale 1ns/1ps
module rfifo_ptr_sync #(
    parameter int PTR_W  = 10,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] gray_in,
    output logic [PTR_W-1:0] bin_out
);

    logic [PTR_W-1:0] stage_q [STAGES];
    logic [PTR_W-1:0] gray_sync;

    // Chain of capture flops in the destination domain.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= gray_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign gray_sync = stage_q[STAGES-1];

    // Gray to binary: each bit is the parity of all bits at or above it.
    for (genvar b = 0; b < PTR_W; b++) begin : g_g2b
        assign bin_out[b] = ^(gray_sync >> b);
    end

endmodule

// File: rtl/rfifo_array.sv
`timescale 1ns/1ps
module rfifo_array #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 9
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem[wr_addr] <= wr_data;
    end

    // Unregistered read; the read side captures it in its output register.
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/rfifo_wr_side.sv
`timescale 1ns/1ps
module rfifo_wr_side
    import rfifo_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              dir,
    input  logic              wen,
    input  logic [ADDR_W:0]   rd_bin_sync,
    output logic              in_ready,
    output logic              half_full,
    output logic              push,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W:0]   wr_gray
);

    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int HALF  = DEPTH / 2;

    wr_state_e        state_q, state_d;
    logic [PTR_W-1:0] wr_bin_q, wr_bin_d, level_d, wr_gray_q;
    logic             full_d, hf_q;

    // Datapath next values.
    always_comb begin
        push     = (state_q == WS_OPEN) && !cs_n && dir && wen;
        wr_bin_d = wr_bin_q + PTR_W'(push);
        level_d  = wr_bin_d - rd_bin_sync;
        full_d   = (level_d == PTR_W'(DEPTH));
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_RESET: state_d = WS_ARM;
            WS_ARM:   state_d = WS_OPEN;
            WS_OPEN:  if (full_d) state_d = WS_FULL;
            WS_FULL:  if (!full_d) state_d = WS_OPEN;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_RESET;
        else        state_q <= state_d;
    end

    // Pointer and level registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_bin_q  <= '0;
            wr_gray_q <= '0;
            hf_q      <= 1'b0;
        end else begin
            wr_bin_q  <= wr_bin_d;
            wr_gray_q <= wr_bin_d ^ (wr_bin_d >> 1);
            hf_q      <= (level_d >= PTR_W'(HALF));
        end
    end

    // Outputs.
    always_comb begin
        in_ready  = (state_q == WS_OPEN);
        half_full = hf_q;
        wr_addr   = wr_bin_q[ADDR_W-1:0];
        wr_gray   = wr_gray_q;
    end

    // R7: the array never holds more words than its depth.
    a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (PTR_W'(wr_bin_q - rd_bin_sync) <= PTR_W'(DEPTH)));

    // R1: an unselected or disabled cycle stores nothing.
    a_r1_idle_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || !dir || !wen) |=> $stable(wr_bin_q));

    // R4: the flag stays low through the wake-up state.
    a_r4_wake_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_RESET) |=> !in_ready);

    // R6: the crossing pointer changes by at most one bit per edge.
    a_r6_gray_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(wr_gray_q ^ $past(wr_gray_q)) <= 1));

endmodule

// File: rtl/rfifo_rd_side.sv
`timescale 1ns/1ps
module rfifo_rd_side
    import rfifo_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              dir,
    input  logic              ren,
    input  logic [ADDR_W:0]   wr_bin_sync,
    input  logic [DATA_W-1:0] mem_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W:0]   rd_gray,
    output logic [DATA_W-1:0] dout,
    output logic              out_ready,
    output logic              oe
);

    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    rd_state_e         state_q, state_d;
    logic [PTR_W-1:0]  rd_bin_q, rd_bin_d, rd_gray_q;
    logic [DATA_W-1:0] word_q;
    logic              avail, take, load;

    // Datapath next values.
    always_comb begin
        avail    = (wr_bin_sync != rd_bin_q);
        take     = (state_q == RS_VALID) && !cs_n && !dir && ren;
        load     = avail && ((state_q == RS_EMPTY) || take);
        rd_bin_d = rd_bin_q + PTR_W'(load);
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_EMPTY: if (load) state_d = RS_VALID;
            RS_VALID: if (take && !load) state_d = RS_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_EMPTY;
        else        state_q <= state_d;
    end

    // Pointer and output word registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_bin_q  <= '0;
            rd_gray_q <= '0;
            word_q    <= '0;
        end else begin
            rd_bin_q  <= rd_bin_d;
            rd_gray_q <= rd_bin_d ^ (rd_bin_d >> 1);
            if (load) word_q <= mem_data;
        end
    end

    // Outputs.
    always_comb begin
        out_ready = (state_q == RS_VALID);
        oe        = !cs_n && !dir;
        dout      = word_q;
        rd_addr   = rd_bin_q[ADDR_W-1:0];
        rd_gray   = rd_gray_q;
    end

    // R2: the read pointer never runs past the synchronized write pointer.
    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (PTR_W'(wr_bin_sync - rd_bin_q) <= PTR_W'(DEPTH)));

    // R8: while not ready, the last word is held.
    a_r8_hold_last: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |=> (out_ready || $stable(dout)));

    // R8: the ready flag only falls on an edge that took a word.
    a_r8_fall_on_take: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_ready) |-> $past(!cs_n && !dir && ren));

    // R6: the crossing pointer changes by at most one bit per edge.
    a_r6_rd_gray_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(rd_gray_q ^ $past(rd_gray_q)) <= 1));

endmodule

// File: rtl/dual_clock_ready_fifo.sv
`timescale 1ns/1ps
module dual_clock_ready_fifo #(
    parameter int DATA_W      = 18,
    parameter int ADDR_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_cs_n,
    input  logic              wr_dir,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              wr_half_full,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_cs_n,
    input  logic              rd_dir,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ready,
    output logic              rd_oe
);

    localparam int PTR_W = ADDR_W + 1;

    logic              push;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [PTR_W-1:0]  wr_gray, rd_gray, rd_bin_at_wr, wr_bin_at_rd;
    logic [DATA_W-1:0] mem_q;

    rfifo_wr_side #(.ADDR_W(ADDR_W)) u_wr (
        .clk         (wr_clk),
        .rst_n       (wr_rst_n),
        .cs_n        (wr_cs_n),
        .dir         (wr_dir),
        .wen         (wr_en),
        .rd_bin_sync (rd_bin_at_wr),
        .in_ready    (wr_ready),
        .half_full   (wr_half_full),
        .push        (push),
        .wr_addr     (wr_addr),
        .wr_gray     (wr_gray)
    );

    rfifo_ptr_sync #(.PTR_W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_to_wr (
        .clk     (wr_clk),
        .rst_n   (wr_rst_n),
        .gray_in (rd_gray),
        .bin_out (rd_bin_at_wr)
    );

    rfifo_ptr_sync #(.PTR_W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_to_rd (
        .clk     (rd_clk),
        .rst_n   (rd_rst_n),
        .gray_in (wr_gray),
        .bin_out (wr_bin_at_rd)
    );

    rfifo_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
        .wr_clk  (wr_clk),
        .we      (push),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (mem_q)
    );

    rfifo_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .clk         (rd_clk),
        .rst_n       (rd_rst_n),
        .cs_n        (rd_cs_n),
        .dir         (rd_dir),
        .ren         (rd_en),
        .wr_bin_sync (wr_bin_at_rd),
        .mem_data    (mem_q),
        .rd_addr     (rd_addr),
        .rd_gray     (rd_gray),
        .dout        (rd_data),
        .out_ready   (rd_ready),
        .oe          (rd_oe)
    );

endmodule

// File: tb/tb_dual_clock_ready_fifo.sv
`timescale 1ns/1ps
module tb_dual_clock_ready_fifo;

    localparam int DW         = 18;
    localparam int AW         = 9;
    localparam int DEPTH      = 1 << AW;
    localparam int RAND_WORDS = 700;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic          wr_cs_n = 1'b1, wr_dir = 1'b0, wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_cs_n = 1'b1, rd_dir = 1'b1, rd_en = 1'b0;
    logic          wr_ready, wr_half_full, rd_ready, rd_oe;
    logic [DW-1:0] rd_data;

    dual_clock_ready_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) dut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_cs_n(wr_cs_n), .wr_dir(wr_dir),
        .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready), .wr_half_full(wr_half_full),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_cs_n(rd_cs_n), .rd_dir(rd_dir),
        .rd_en(rd_en), .rd_data(rd_data), .rd_ready(rd_ready), .rd_oe(rd_oe)
    );

    int checks = 0;
    int errors = 0;
    int rd_edges = 0;
    int wr_snap = 0;
    logic [DW-1:0] model [$];

    // 200 MHz write clock; unrelated read clock whose edges never meet it.
    always #2.5 wr_clk = ~wr_clk;
    initial begin
        #0.65;
        forever begin
            rd_clk = 1'b1; #3.7;
            rd_clk = 1'b0; #3.7;
        end
    end
    always @(posedge rd_clk) rd_edges++;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_step(input logic cs_n, input logic dir, input logic en,
                           input logic [DW-1:0] d, output bit acc);
        wr_cs_n = cs_n; wr_dir = dir; wr_en = en; wr_data = d;
        acc = !cs_n && dir && en && wr_ready;
        @(posedge wr_clk);
        wr_snap = rd_edges;
        if (acc) model.push_back(d);
        #1;
    endtask

    task automatic rd_step(input logic cs_n, input logic dir, input logic en, output bit took);
        rd_cs_n = cs_n; rd_dir = dir; rd_en = en;
        took = !cs_n && !dir && en && rd_ready;
        @(posedge rd_clk);
        if (took) void'(model.pop_front());
        #1;
    endtask

    task automatic wait_rd_ready(input int limit);
        int n = 0;
        while (!rd_ready && n < limit) begin
            @(posedge rd_clk); #1; n++;
        end
    endtask

    initial begin
        #900000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit acc, took;
        int n, c, snap;
        void'($urandom(32'd2024));

        // R4: reset state, then wake-up timing of wr_ready.
        repeat (4) @(posedge wr_clk);
        #1;
        chk("R4", "wr_ready in reset", wr_ready, 0);
        chk("R4", "rd_ready in reset", rd_ready, 0);
        chk("R4", "half-full in reset", wr_half_full, 0);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        n = 0;
        while (!wr_ready && n < 10) begin
            @(posedge wr_clk); #1; n++;
        end
        chk("R4", "write edges until wr_ready", n, 2);

        // R1: writes with a wrong select, direction or enable store nothing.
        wr_step(1'b1, 1'b1, 1'b1, 18'h11111, acc);
        wr_step(1'b0, 1'b0, 1'b1, 18'h22222, acc);
        wr_step(1'b0, 1'b1, 1'b0, 18'h33333, acc);
        wr_cs_n = 1'b1;
        repeat (8) @(posedge rd_clk);
        #1;
        chk("R1", "rd_ready after ignored writes", rd_ready, 0);
        chk("R1", "wr_ready after ignored writes", wr_ready, 1);

        // R3: output enable for every select/direction pair.
        for (int i = 0; i < 4; i++) begin
            rd_cs_n = i[1]; rd_dir = i[0]; rd_en = 1'b0;
            #0.2;
            chk("R3", "rd_oe", rd_oe, (i == 0) ? 1 : 0);
        end
        rd_cs_n = 1'b1;

        // R5: first-word fall-through latency and data.
        wr_step(1'b0, 1'b1, 1'b1, 18'h2A5A5, acc);
        snap = wr_snap;
        wr_cs_n = 1'b1;
        while (!rd_ready && (rd_edges - snap) < 12) begin
            @(posedge rd_clk); #1;
        end
        chk("R5", "read edges from write to rd_ready", rd_edges - snap, 3);
        chk("R5", "first word on rd_data", rd_data, 18'h2A5A5);

        // R8: reading the last word drops the flag and holds the data.
        rd_step(1'b0, 1'b0, 1'b1, took);
        chk("R8", "rd_ready after last word taken", rd_ready, 0);
        chk("R8", "last word held", rd_data, 18'h2A5A5);
        // R2: reads while not ready are ignored.
        for (int i = 0; i < 3; i++) begin
            rd_step(1'b0, 1'b0, 1'b1, took);
            chk("R2", "data held on blocked read", rd_data, 18'h2A5A5);
            chk("R2", "rd_ready on blocked read", rd_ready, 0);
        end
        rd_cs_n = 1'b1;

        // R7 and R9: fill with the reader stopped.
        wr_step(1'b0, 1'b1, 1'b1, 18'h0, acc);
        wr_cs_n = 1'b1;
        wait_rd_ready(20);
        repeat (6) @(posedge wr_clk);
        #1;
        c = 0;
        while (wr_ready && c < 600) begin
            wr_step(1'b0, 1'b1, 1'b1, DW'(c + 1), acc);
            c++;
            if (c == 255) chk("R9", "half-full at 255 array words", wr_half_full, 0);
            if (c == 256) chk("R9", "half-full at 256 array words", wr_half_full, 1);
        end
        chk("R7", "words accepted behind the head word", c, DEPTH);
        for (int i = 0; i < 3; i++) wr_step(1'b0, 1'b1, 1'b1, 18'h3FFFF, acc);
        wr_cs_n = 1'b1;
        chk("R7", "wr_ready low while full", wr_ready, 0);

        // R2: a read with the write direction selected does not advance.
        rd_step(1'b0, 1'b1, 1'b1, took);
        chk("R2", "head word unchanged by wrong-direction read", rd_data, 18'h0);
        chk("R2", "rd_ready unchanged by wrong-direction read", rd_ready, 1);

        // R6: drain in order.
        n = 0;
        while (model.size() > 0 && n < 2000) begin
            chk("R6", "rd_ready during drain", rd_ready, 1);
            chk("R6", "drain order", rd_data, model[0]);
            rd_step(1'b0, 1'b0, 1'b1, took);
            n++;
        end
        rd_cs_n = 1'b1;
        repeat (2) @(posedge rd_clk);
        #1;
        chk("R8", "rd_ready after drain", rd_ready, 0);
        chk("R8", "last drained word held", rd_data, 18'd512);
        repeat (6) @(posedge wr_clk);
        #1;
        chk("R7", "wr_ready back after drain", wr_ready, 1);
        chk("R9", "half-full cleared after drain", wr_half_full, 0);

        // R6: random traffic, a slow reader first to force full stalls.
        fork
            begin
                int c2;
                int r;
                bit a2;
                c2 = 0;
                while (c2 < RAND_WORDS) begin
                    r = $urandom_range(7);
                    if (r < 5)       wr_step(1'b0, 1'b1, 1'b1, DW'($urandom), a2);
                    else if (r == 5) wr_step(1'b1, 1'b1, 1'b1, DW'($urandom), a2);
                    else if (r == 6) wr_step(1'b0, 1'b0, 1'b1, DW'($urandom), a2);
                    else             wr_step(1'b0, 1'b1, 1'b0, DW'($urandom), a2);
                    if (a2) c2++;
                end
                wr_cs_n = 1'b1;
            end
            begin
                int got;
                int r;
                bit t2;
                got = 0;
                while (got < RAND_WORDS) begin
                    if (rd_ready)
                        chk("R6", "random order", rd_data, (model.size() > 0) ? model[0] : '1);
                    r = $urandom_range(7);
                    if ((got < 200 && r == 0) || (got >= 200 && r < 6))
                        rd_step(1'b0, 1'b0, 1'b1, t2);
                    else if (r == 6)
                        rd_step(1'b0, 1'b1, 1'b1, t2);
                    else
                        rd_step(1'b1, 1'b0, 1'b1, t2);
                    if (t2) got++;
                end
                rd_cs_n = 1'b1;
            end
        join
        repeat (4) @(posedge rd_clk);
        #1;
        chk("R6", "no words left after random traffic", model.size(), 0);
        chk("R8", "rd_ready low after random traffic", rd_ready, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule